// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block brings a single-data-rate SDRAM from power-up to a usable state and then opens and closes rows on request. Software places an operation code and a CAS latency value on the block's inputs and pulses a trigger; each trigger launches one step of the power-up procedure. The steps are a precharge of all banks, then a burst of eight auto refreshes, then a write of the device's mode register. A reset on its own issues no command. Triggers that arrive out of order, or while a timing gap is still running, are dropped.

Once the mode register has been written and its settling gap has passed, the block raises `ready` and accepts row requests. A request either activates a row in a bank or precharges one bank. A bank that holds an open row must be precharged before it can be activated again. Every command leaves the block from a register, so each command is stable for a full cycle around the rising edge at which the SDRAM samples it. The minimum spacing between commands is kept by inserting NOP cycles.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset the command pins {cs_n, ras_n, cas_n, we_n} show NOP (0111), `addr` is zero and `ready` is low. They stay that way until a valid trigger arrives, so reset alone issues no command.
- R2: While the block waits for its first step, a trigger with op code 01 produces a PRECHARGE (0010) with addr[10]=1 in the next cycle. A trigger with op code 10 or 11 in that phase produces only NOP.
- R3: After the precharge, a trigger with op code 10 produces exactly NREF (8) REFRESH commands (0001). Each one comes TRFC cycles after the previous one, with NOP in between, and no further refresh follows.
- R4: A trigger that arrives while the gap after the precharge is still running is ignored.
- R5: After the refreshes, a trigger with op code 11 produces a MODE-SET (0000). On that cycle addr[6:4] carries `cas_lat` and all bits above addr[6] are zero.
- R6: The mode word always has addr[3]=0 (sequential burst). addr[2:0] is 010 (burst of 4) when PORT_64=1 and 011 (burst of 8) when PORT_64=0. No other burst code is ever produced.
- R7: A mode-set trigger with `cas_lat` outside 1..4 is ignored, and `ready` stays low.
- R8: `ready` and `req_ready` stay low until TMRD-1 cycles after the MODE-SET cycle. A row request arriving earlier is stalled, so the first ACTIVATE comes exactly TMRD cycles after the MODE-SET.
- R9: Once `ready` is high, an accepted request with req_close=0 produces ACTIVATE (0011) in the next cycle, with `ba`=req_bank and `addr`=req_row. An accepted request with req_close=1 produces PRECHARGE with addr[10]=0 and `ba`=req_bank.
- R10: An activate request to a bank that already has an open row is held off (`req_ready` low, NOP on the pins) until that bank is precharged.
- R11: After a normal-mode ACTIVATE the next command comes no earlier than TRCD cycles later. After a normal-mode PRECHARGE the next command comes no earlier than TRP cycles later.
- R12: Once `ready` is high, triggers of any op code produce no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the SDRAM samples on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 2 | Power-up step: 01 precharge-all, 10 refresh burst, 11 mode-set |
| cas_lat | input | 3 | CAS latency for the mode word (1..4) |
| trig | input | 1 | One-cycle strobe that launches the step given by op_code |
| req_valid | input | 1 | A row request is present |
| req_close | input | 1 | 1 precharges the bank, 0 activates the row |
| req_bank | input | BANK_W | Bank of the request |
| req_row | input | ADDR_W | Row address for an activate |
| req_ready | output | 1 | The request is accepted on this edge |
| ready | output | 1 | Power-up procedure has finished |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address / mode word |
| ba | output | BANK_W | Bank address |

## Verification
The bench repeats the whole power-up procedure for every `cas_lat` code from 0 to 7. The legal codes show that the latency lands in addr[6:4], and the illegal codes show that the block refuses the mode-set and keeps `ready` low. In each pass, out-of-order and too-early triggers are mixed in, which separates step ordering from gap enforcement. A 32-bit-port copy runs in lock-step with the 64-bit one, so the two differ only in the burst code. Requests after power-up re-activate an open bank, close it, and then activate a second bank. This exercises the open-bank stall separately from the TRP and TRCD spacing.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter bit PORT_64 = 1'b1,
  parameter int ADDR_W  = 13,
  parameter int BANK_W  = 2,
  parameter int NREF    = 8,
  parameter int TRP     = 2,
  parameter int TRFC    = 3,
  parameter int TMRD    = 2,
  parameter int TRCD    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_code,
  input  logic [2:0]        cas_lat,
  input  logic              trig,
  input  logic              req_valid,
  input  logic              req_close,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] req_row,
  output logic              req_ready,
  output logic              ready,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba
);

  localparam int NBANK = 1 << BANK_W;
  localparam int G1    = (TRP > TRFC) ? TRP : TRFC;
  localparam int G2    = (TMRD > TRCD) ? TMRD : TRCD;
  localparam int GMAX  = (G1 > G2) ? G1 : G2;
  localparam int GAP_W = $clog2(GMAX) + 1;
  localparam int REF_W = $clog2(NREF + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  localparam logic [2:0]        BL_CODE = PORT_64 ? 3'b010 : 3'b011;
  localparam logic [ADDR_W-1:0] A10_BIT = ADDR_W'(1) << 10;

  typedef enum logic [1:0] {PH_PRE, PH_REF, PH_MRS, PH_DONE} phase_t;

  phase_t              ph;
  logic [3:0]          cmd_q;
  logic [GAP_W-1:0]    gap_q;
  logic [REF_W-1:0]    ref_left;
  logic [NBANK-1:0]    open_q;

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;

  wire idle   = (gap_q == '0) && (ref_left == '0);
  wire cas_ok = (cas_lat >= 3'd1) && (cas_lat <= 3'd4);
  wire go_pre = trig && idle && ph == PH_PRE && op_code == 2'b01;
  wire go_ref = trig && idle && ph == PH_REF && op_code == 2'b10;
  wire go_mrs = trig && idle && ph == PH_MRS && op_code == 2'b11 && cas_ok;

  wire [ADDR_W-1:0] mode_word = {{(ADDR_W-7){1'b0}}, cas_lat, 1'b0, BL_CODE};

  assign ready     = (ph == PH_DONE) && (gap_q == '0);
  assign req_ready = ready && !(!req_close && open_q[req_bank]);
  wire   take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= PH_PRE;
      cmd_q    <= C_NOP;
      addr     <= '0;
      ba       <= '0;
      gap_q    <= '0;
      ref_left <= '0;
      open_q   <= '0;
    end else begin
      cmd_q <= C_NOP;
      addr  <= '0;
      ba    <= '0;
      if (gap_q != '0) gap_q <= gap_q - 1'b1;
      if (gap_q == '0) begin
        if (ref_left != '0) begin
          cmd_q    <= C_REF;
          ref_left <= ref_left - 1'b1;
          gap_q    <= GAP_W'(TRFC - 1);
          if (ref_left == REF_W'(1)) ph <= PH_MRS;
        end else if (go_pre) begin
          cmd_q <= C_PRE;
          addr  <= A10_BIT;
          gap_q <= GAP_W'(TRP - 1);
          ph    <= PH_REF;
        end else if (go_ref) begin
          cmd_q    <= C_REF;
          ref_left <= REF_W'(NREF - 1);
          gap_q    <= GAP_W'(TRFC - 1);
          if (NREF == 1) ph <= PH_MRS;
        end else if (go_mrs) begin
          cmd_q <= C_MRS;
          addr  <= mode_word;
          gap_q <= GAP_W'(TMRD - 1);
          ph    <= PH_DONE;
        end else if (take) begin
          ba <= req_bank;
          if (req_close) begin
            cmd_q            <= C_PRE;
            gap_q            <= GAP_W'(TRP - 1);
            open_q[req_bank] <= 1'b0;
          end else begin
            cmd_q            <= C_ACT;
            addr             <= req_row;
            gap_q            <= GAP_W'(TRCD - 1);
            open_q[req_bank] <= 1'b1;
          end
        end
      end
    end
  end

  logic [REF_W-1:0] ref_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) ref_seen <= '0;
    else if (cmd_q == C_REF && ref_seen != REF_W'(NREF)) ref_seen <= ref_seen + 1'b1;
  end

  assert_pre_all_a10_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_PRE && !ready && ph == PH_REF && ref_seen == '0) |-> addr[10]);

  assert_refs_before_mrs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_MRS) |-> (ref_seen == REF_W'(NREF)));

  assert_mrs_cas_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_MRS) |-> (addr[6:4] >= 3'd1 && addr[6:4] <= 3'd4 && addr[3] == 1'b0));

  assert_act_after_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_ACT) |-> (ph == PH_DONE));

  assert_act_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_ACT) |-> ((($past(open_q) >> ba) & NBANK'(1)) == '0));

  assert_gap_nop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gap_q) != '0) |-> (cmd_q == C_NOP));

endmodule

// File: tb/sdram_init_seq_test.sv
`timescale 1ns/1ps
module sdram_init_seq_test;
  localparam int TRP = 2, TRFC = 3, TMRD = 2, TRCD = 2, NREF = 8;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, PRE = 4'b0010,
                         REF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0, req_valid = 1'b0, req_close = 1'b0;
  logic [1:0] op = 2'b00, bank = 2'd0;
  logic [2:0] cas = 3'd2;
  logic [12:0] row = '0;
  logic rdy, rrdy, c0, c1, c2, c3, rdy2, rrdy2, d0, d1, d2, d3;
  logic [12:0] addr, addr2;
  logic [1:0] ba, ba2;
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sdram_init_seq #(.PORT_64(1'b1), .TRP(TRP), .TRFC(TRFC), .TMRD(TMRD), .TRCD(TRCD), .NREF(NREF)) uut (
    .clk(clk), .rst_n(rst_n), .op_code(op), .cas_lat(cas), .trig(trig),
    .req_valid(req_valid), .req_close(req_close), .req_bank(bank), .req_row(row),
    .req_ready(rrdy), .ready(rdy), .cs_n(c0), .ras_n(c1), .cas_n(c2), .we_n(c3),
    .addr(addr), .ba(ba));

  sdram_init_seq #(.PORT_64(1'b0), .TRP(TRP), .TRFC(TRFC), .TMRD(TMRD), .TRCD(TRCD), .NREF(NREF)) uut32 (
    .clk(clk), .rst_n(rst_n), .op_code(op), .cas_lat(cas), .trig(trig),
    .req_valid(req_valid), .req_close(req_close), .req_bank(bank), .req_row(row),
    .req_ready(rrdy2), .ready(rdy2), .cs_n(d0), .ras_n(d1), .cas_n(d2), .we_n(d3),
    .addr(addr2), .ba(ba2));

  wire [3:0] cmd  = {c0, c1, c2, c3};
  wire [3:0] cmd2 = {d0, d1, d2, d3};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check(cmd == cmd2 && ba == ba2 && rdy == rdy2, "R6", int'(cmd2), int'(cmd));
  endtask

  task automatic fire(input logic [1:0] o);
    op = o; trig = 1'b1;
    step();
    trig = 1'b0;
  endtask

  task automatic run(input int c);
    rst_n = 1'b0; trig = 1'b0; req_valid = 1'b0; req_close = 1'b0; cas = 3'd2;
    step(); step();
    rst_n = 1'b1;
    #1;
    check(cmd == NOP, "R1", int'(cmd), int'(NOP));
    check(rdy == 1'b0, "R1", int'(rdy), 0);
    check(addr == '0, "R1", int'(addr), 0);
    repeat (3) step();
    check(cmd == NOP, "R1", int'(cmd), int'(NOP));

    fire(2'b10); check(cmd == NOP, "R2", int'(cmd), int'(NOP));
    fire(2'b11); check(cmd == NOP, "R2", int'(cmd), int'(NOP));
    fire(2'b01);
    check(cmd == PRE && addr[10], "R2", int'(cmd), int'(PRE));
    fire(2'b10); check(cmd == NOP, "R4", int'(cmd), int'(NOP));

    fire(2'b10); check(cmd == REF, "R3", int'(cmd), int'(REF));
    for (int i = 1; i < NREF; i++) begin
      for (int k = 1; k < TRFC; k++) begin
        step(); check(cmd == NOP, "R3", int'(cmd), int'(NOP));
      end
      step(); check(cmd == REF, "R3", int'(cmd), int'(REF));
    end
    for (int k = 0; k < TRFC + 2; k++) begin
      step(); check(cmd == NOP, "R3", int'(cmd), int'(NOP));
    end

    cas = 3'(c);
    fire(2'b11);
    if (c < 1 || c > 4) begin
      check(cmd == NOP, "R7", int'(cmd), int'(NOP));
      for (int k = 0; k < 4; k++) begin
        step(); check(rdy == 1'b0, "R7", int'(rdy), 0);
      end
      return;
    end
    check(cmd == MRS, "R5", int'(cmd), int'(MRS));
    check(addr == 13'((c << 4) | 2), "R5", int'(addr), (c << 4) | 2);
    check(addr2 == 13'((c << 4) | 3), "R6", int'(addr2), (c << 4) | 3);

    bank = 2'd1; row = 13'h0A5 + 13'(c); req_close = 1'b0; req_valid = 1'b1;
    #1;
    check(rdy == 1'b0 && rrdy == 1'b0, "R8", int'({rdy, rrdy}), 0);
    for (int k = 1; k < TMRD - 1; k++) begin
      step(); check(rdy == 1'b0, "R8", int'(rdy), 0);
    end
    step(); check(rdy == 1'b1, "R8", int'(rdy), 1);
    step();
    check(cmd == ACT && ba == 2'd1 && addr == row, "R9", int'(cmd), int'(ACT));

    for (int k = 0; k < 4; k++) begin
      step();
      check(cmd == NOP, "R10", int'(cmd), int'(NOP));
      check(rrdy == 1'b0, "R10", int'(rrdy), 0);
    end

    req_close = 1'b1;
    step();
    check(cmd == PRE && !addr[10] && ba == 2'd1, "R9", int'(cmd), int'(PRE));
    req_close = 1'b0;
    #1;
    check(rrdy == 1'b0, "R11", int'(rrdy), 0);
    for (int k = 1; k < TRP; k++) begin
      step(); check(cmd == NOP, "R11", int'(cmd), int'(NOP));
    end
    step(); check(cmd == ACT && ba == 2'd1, "R11", int'(cmd), int'(ACT));

    bank = 2'd2;
    for (int k = 1; k < TRCD; k++) begin
      step(); check(cmd == NOP, "R11", int'(cmd), int'(NOP));
    end
    step(); check(cmd == ACT && ba == 2'd2, "R11", int'(cmd), int'(ACT));
    req_valid = 1'b0;

    step();
    fire(2'b01); check(cmd == NOP, "R12", int'(cmd), int'(NOP));
    fire(2'b10); check(cmd == NOP, "R12", int'(cmd), int'(NOP));
    fire(2'b11); check(cmd == NOP, "R12", int'(cmd), int'(NOP));
    check(rdy == 1'b1, "R12", int'(rdy), 1);
  endtask

  initial begin
    for (int c = 0; c < 8; c++) run(c);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule